// File: doc/BRIEF.md
# Accumulated Hash Padding Detector

When a message is hashed in accumulate mode, software delivers it as a series of requests and appends the final padding itself. This block watches that series and finds the end. For each request it adds the request length to a running byte total. It reads the big-endian bit count in the last eight bytes of the request and converts it to a byte count. From these values it works out where padding would begin if this were the closing request. It then fetches the byte at that position through a byte-read port. If the byte is the padding start marker, the request is final.

The result tells a downstream hash core how many bytes of the request are message bytes, and whether the digest must be closed. The final decision comes only from the request contents. A descriptor's end-of-list flag does not decide it. The hash core and the request buffer are outside this block. The buffer answers the read port one cycle after the read is issued.

Top module: `acc_pad_detect`

## Requirements
- R1: After reset the running total is zero, `busy_o`, `rd_en_o` and `res_valid_o` are low, and the first request is judged against a total equal to its own length.
- R2: The running total grows by each accepted request's length, and the check of that request uses the total after the addition.
- R3: The message byte length is the 64-bit tail value (byte 0 most significant) shifted right by three, keeping its low 32 bits. Tail bits [2:0] and [63:35] have no effect.
- R4: When the message byte length is greater than the running total, the request is not final and no byte is read.
- R5: Padding size is the total minus the message length, and the candidate offset is the request length minus that size. An offset below zero, or not below the request length, means no padding: `rd_en_o` stays low and the request is not final.
- R6: For an in-range offset, `rd_en_o` is high for one cycle with `rd_addr_o` equal to the offset. The request is final only if the byte returned on `rd_data_i` one cycle later equals 0x80.
- R7: A final result reports `pad_off_o` equal to the offset and clears the running total. A non-final result reports `pad_off_o` equal to the request length and keeps the total.
- R8: A request is accepted when `req_valid_i` is high and `busy_o` is low. `busy_o` then stays high for two cycles, and `res_valid_o` pulses for one cycle after the second rising edge that follows acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, sampled while not busy |
| req_len_i | input | LEN_W | Request length in bytes |
| tail_i | input | 64 | Last eight request bytes as a big-endian value |
| busy_o | output | 1 | Request in progress |
| rd_en_o | output | 1 | Byte read strobe into the request buffer |
| rd_addr_o | output | LEN_W | Byte offset being read |
| rd_data_i | input | 8 | Byte returned one cycle after the read |
| res_valid_o | output | 1 | One-cycle result strobe |
| final_o | output | 1 | Request carries the closing padding |
| pad_off_o | output | LEN_W | Number of leading message bytes to hash |

## Verification
A running total that is wrong shows up at the next request whose tail is consistent with the true total. That request's read address is wrong, or the read is missing, and this is visible one cycle after acceptance. Its final flag and offset are also wrong, and this is visible two cycles after acceptance. The bench therefore replays a long stream of final and non-final requests against its own total, so that a missed clear or a stale total corrupts every later result. It sweeps every request length up to twelve against padding sizes below zero, zero, in range, and beyond the length. It also places the marker both present and absent, and fills the buffer with marker bytes so that a read at a wrong address is caught.

// File: rtl/acc_pad_detect_pkg.sv
package acc_pad_detect_pkg;
  localparam logic [7:0] PAD_MARK = 8'h80;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_CMP  = 2'd2
  } pad_state_e;
endpackage

// File: rtl/pad_total_acc.sv
module pad_total_acc #(
  parameter int TOT_W = 32,
  parameter int LEN_W = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             add_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             clr_i,
  output logic [TOT_W-1:0] sum_o
);
  logic [TOT_W-1:0] total_q;

  assign sum_o = total_q + TOT_W'(len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      total_q <= '0;
    else if (clr_i)   total_q <= '0;
    else if (add_i)   total_q <= sum_o;
  end

  p_clear_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> total_q == '0);
  p_no_add_on_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_i && add_i));
endmodule

// File: rtl/pad_offset_calc.sv
module pad_offset_calc #(
  parameter int TOT_W = 32,
  parameter int LEN_W = 28
) (
  input  logic [TOT_W-1:0] sum_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [63:0]      tail_i,
  output logic             cand_o,
  output logic [LEN_W-1:0] off_o
);
  logic [TOT_W-1:0] msg_len;
  logic [TOT_W-1:0] pad_sz;
  logic [TOT_W-1:0] len_ext;
  logic [2:0]       tail_unused_lo;
  logic [63-TOT_W-3:0] tail_unused_hi;

  // bit count to byte count, truncated
  assign msg_len        = tail_i[TOT_W+2:3];
  assign tail_unused_lo = tail_i[2:0];
  assign tail_unused_hi = tail_i[63:TOT_W+3];

  assign len_ext = TOT_W'(len_i);
  assign pad_sz  = sum_i - msg_len;
  assign off_o   = len_i - pad_sz[LEN_W-1:0];
  // offset in [0, len) <=> pad size in (0, len]
  assign cand_o  = (msg_len <= sum_i) && (pad_sz != '0) && (pad_sz <= len_ext);

  always_comb begin
    if (cand_o) p_off_in_range_r5: assert (off_o < len_i);
  end
endmodule

// File: rtl/acc_pad_detect.sv
module acc_pad_detect
  import acc_pad_detect_pkg::*;
#(
  parameter int TOT_W = 32,
  parameter int LEN_W = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic [63:0]      tail_i,
  output logic             busy_o,
  output logic             rd_en_o,
  output logic [LEN_W-1:0] rd_addr_o,
  input  logic [7:0]       rd_data_i,
  output logic             res_valid_o,
  output logic             final_o,
  output logic [LEN_W-1:0] pad_off_o
);
  pad_state_e       state_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] off_q;
  logic             cand_q;
  logic [TOT_W-1:0] sum;
  logic             calc_cand;
  logic [LEN_W-1:0] calc_off;
  logic             accept;
  logic             hit;

  assign accept = req_valid_i && (state_q == ST_IDLE);
  assign hit    = (state_q == ST_CMP) && cand_q && (rd_data_i == PAD_MARK);

  pad_total_acc #(.TOT_W(TOT_W), .LEN_W(LEN_W)) u_total (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .add_i  (accept),
    .len_i  (req_len_i),
    .clr_i  (hit),
    .sum_o  (sum)
  );

  pad_offset_calc #(.TOT_W(TOT_W), .LEN_W(LEN_W)) u_calc (
    .sum_i  (sum),
    .len_i  (req_len_i),
    .tail_i (tail_i),
    .cand_o (calc_cand),
    .off_o  (calc_off)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      len_q       <= '0;
      off_q       <= '0;
      cand_q      <= 1'b0;
      res_valid_o <= 1'b0;
      final_o     <= 1'b0;
      pad_off_o   <= '0;
    end else begin
      res_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          len_q   <= req_len_i;
          off_q   <= calc_off;
          cand_q  <= calc_cand;
          state_q <= ST_READ;
        end
        ST_READ: state_q <= ST_CMP;
        ST_CMP: begin
          res_valid_o <= 1'b1;
          final_o     <= hit;
          pad_off_o   <= hit ? off_q : len_q;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign rd_en_o   = (state_q == ST_READ) && cand_q;
  assign rd_addr_o = off_q;

  p_result_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> ##2 res_valid_o);
  p_result_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
  p_no_req_when_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_valid_i);
  p_final_after_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && final_o) |-> $past(rd_en_o, 2));
  p_read_in_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> rd_addr_o < len_q);
  p_off_bounded_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (final_o ? pad_off_o < len_q : pad_off_o == len_q));
endmodule

// File: tb/sim_acc_pad_detect.sv
`timescale 1ns/100ps
module sim_acc_pad_detect;
  localparam int LW = 28;
  localparam int TW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [LW-1:0] req_len = '0;
  logic [63:0]   tail = '0;
  logic          busy, rd_en, res_valid, fin;
  logic [LW-1:0] rd_addr, pad_off;
  logic [7:0]    rd_data = '0;
  logic [7:0]    mem_b [16];

  int     errs = 0;
  int     checks = 0;
  longint model = 0;
  bit     done = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) if (rd_en) rd_data <= mem_b[rd_addr[3:0]];

  acc_pad_detect #(.TOT_W(TW), .LEN_W(LW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_len_i(req_len),
    .tail_i(tail), .busy_o(busy), .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .res_valid_o(res_valid), .final_o(fin), .pad_off_o(pad_off)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill(input logic [7:0] v);
    for (int i = 0; i < 16; i++) mem_b[i] = v;
  endtask

  task automatic run_req(input int len, input longint tl, input string tag);
    longint tot, m, psz, off, exp_off;
    bit cand, efin;
    tot  = (model + len) & 64'hFFFF_FFFF;
    m    = (tl >> 3) & 64'hFFFF_FFFF;
    psz  = tot - m;
    cand = (m <= tot) && (psz != 0) && (psz <= len);
    off  = len - psz;
    efin = cand && (mem_b[off[3:0]] == 8'h80);
    exp_off = efin ? off : len;
    model = efin ? 0 : tot;

    req_valid = 1'b1; req_len = LW'(len); tail = tl;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R8", busy, 1);
    chk(rd_en == cand, tag, rd_en, cand);
    if (cand) chk(rd_addr == LW'(off), "R6", rd_addr, off);
    @(posedge clk); @(negedge clk);
    chk(res_valid == 1'b0, "R8", res_valid, 0);
    @(posedge clk); @(negedge clk);
    chk(res_valid == 1'b1, "R8", res_valid, 1);
    chk(fin == efin, tag, fin, efin);
    chk(pad_off == LW'(exp_off), "R7", pad_off, exp_off);
    chk(busy == 1'b0, "R8", busy, 0);
  endtask

  function automatic longint mk_tail(input longint m, input longint hi, input longint lo);
    return (hi << 35) | ((m & 64'hFFFF_FFFF) << 3) | (lo & 7);
  endfunction

  initial begin
    fill(8'h80);
    #1;
    chk(busy == 1'b0 && res_valid == 1'b0 && rd_en == 1'b0, "R1", {busy, res_valid, rd_en}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && res_valid == 1'b0, "R1", {busy, res_valid}, 0);

    // first request: message empty, all four bytes padding -> offset 0
    run_req(4, mk_tail(0, 0, 0), "R1");

    // accumulation across requests
    run_req(6, mk_tail(1000, 0, 0), "R4");
    run_req(4, mk_tail(7, 0, 0), "R2");

    // truncation and ignored tail bits
    fill(8'h80);
    run_req(5, mk_tail(2, 64'h1ABCDEF, 5), "R3");

    // sweep of lengths, padding sizes and marker presence
    for (int len = 1; len <= 12; len++) begin
      for (int d = 0; d <= len + 2; d++) begin
        for (int mk = 0; mk < 2; mk++) begin
          longint tot, m;
          string tg;
          tot = model + len;
          fill(8'h80);
          if (mk == 0 && d > 0 && d <= len) mem_b[len - d] = 8'h81;
          m = (d <= tot) ? tot - d : tot + 3;
          if (d > tot) tg = "R4";
          else if (d == 0 || d > len) tg = "R5";
          else tg = "R6";
          run_req(len, mk_tail(m, len * 7 + d, len), tg);
        end
      end
    end

    // reset in the middle of an accumulation
    run_req(5, mk_tail(5000, 0, 0), "R4");
    @(negedge clk); rst_n = 1'b0; model = 0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    fill(8'h80);
    run_req(4, mk_tail(0, 0, 0), "R1");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule